// File: doc/BRIEF.md
# Four-Phase IQ Sampling Demodulator

This block recovers in-phase and quadrature components from a stream of 16-bit ADC samples of an intermediate-frequency signal. The sampling rate is four times the IF, so each new sample sits a quarter turn further along the carrier. The samples therefore arrive in a fixed cycle: +I, +Q, −I, −Q. The block follows that cycle with a two-bit phase counter. It holds the first three samples of each group of four. When the fourth sample arrives, it forms one I word and one Q word. Each word is half the difference of two samples taken half a turn apart. A constant ADC offset appears with the same sign in both samples of a pair, so it drops out of the result. The output pair rate is one quarter of the accepted sample rate.

Samples enter on a valid/ready stream, and I/Q pairs leave on another one. A sample is accepted on a rising clock edge when both `in_valid` and `in_ready` are high. A pair is consumed on an edge when both `out_valid` and `out_ready` are high. While a finished pair waits and `out_ready` is low, the block lowers `in_ready`. The pair and its strobe then stay unchanged until they are taken. The synchronous `resync` input returns the counter to the +I position, so a system reference can align the I/Q assignment.

Top module: `iq_demod_top`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the next accepted sample is taken as the +I sample (phase 0).
- R2: Number the accepted samples s0..s3 in phase order 0..3. The block forms I from s0 − s2 and Q from s1 − s3. Both differences are signed two's complement and computed at 17-bit width.
- R3: Each output word equals floor((d + 1) / 2), where d is its difference. A result of +32768 saturates to 32767, so an output word is never 16'h8000.
- R4: Adding the same constant to all four samples of a group leaves `out_i` and `out_q` unchanged, as long as no sample overflows.
- R5: The edge that accepts the phase-3 sample raises `out_valid` and loads `out_i` and `out_q` together. No other accepted sample sets `out_valid`.
- R6: On an edge with `resync` high, the phase returns to 0. Samples already held for the partial group are discarded. A sample accepted on that edge is dropped.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. On each such edge, `out_valid`, `out_i` and `out_q` keep their values.
- R8: A cycle without an accepted sample leaves the phase and the held samples unchanged. Gaps between samples do not change the result.
- R9: After an edge where the pair is taken (`out_valid` and `out_ready` both 1) and no new group completes, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync | input | 1 | Returns the phase counter to +I and drops the partial group |
| in_valid | input | 1 | ADC sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed ADC sample |
| out_valid | output | 1 | I/Q pair present |
| out_ready | input | 1 | Consumer takes the pair |
| out_i | output | 16 | Signed in-phase word |
| out_q | output | 16 | Signed quadrature word |

## Verification
The assertions allow `in_valid` and `out_ready` to change on any cycle. They do not require the stream inputs to be held steady. They do assume that `resync` is a level that the environment samples cleanly on the clock edge. Their own sample counter is cleared only by reset and `resync`, the same events that clear the design's counter. The stimulus drives all inputs half a cycle away from the active edge. It lowers `resync` and `in_valid` outside the cases where their overlap is the thing under test. The ADC codes it chooses, including the extreme codes used for saturation, are all legal 16-bit values.

// File: rtl/iq_demod_pkg.sv
package iq_demod_pkg;
  // Position of a sample within one carrier period (quarter-turn steps)
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } phase_t;

  localparam int HELD_SAMPLES = 3;
endpackage

// File: rtl/iq_phase_ctr.sv
module iq_phase_ctr
  import iq_demod_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   resync,
  input  logic   adv,
  output phase_t phase,
  output logic   group_done
);
  phase_t ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n || resync) ph_q <= PH_I_POS;
    else if (adv)         ph_q <= phase_t'(ph_q + 2'd1);
  end

  assign phase      = ph_q;
  assign group_done = adv && !resync && (ph_q == PH_Q_NEG);
endmodule

// File: rtl/iq_sample_hold.sv
module iq_sample_hold
  import iq_demod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  phase_t       phase,
  input  logic [W-1:0] din,
  output logic [W-1:0] held [HELD_SAMPLES]
);
  for (genvar k = 0; k < HELD_SAMPLES; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               held[k] <= '0;
      else if (adv && (phase == phase_t'(k)))   held[k] <= din;
    end
  end
endmodule

// File: rtl/iq_half_diff.sv
module iq_half_diff #(
  parameter int W = 16
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] neg,
  output logic [W-1:0] res
);
  localparam int XW = W + 2;
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [XW-1:0] sum;
  logic [W:0]    half;

  always_comb begin
    sum  = {{2{pos[W-1]}}, pos} - {{2{neg[W-1]}}, neg} + XW'(1);
    half = sum[XW-1:1];
    if (half[W] != half[W-1]) res = half[W] ? MINV : MAXV;
    else                      res = half[W-1:0];
  end
endmodule

// File: rtl/iq_out_reg.sv
module iq_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] i_new,
  input  logic [W-1:0] q_new,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] i_out,
  output logic [W-1:0] q_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      i_out <= '0;
      q_out <= '0;
    end else if (load) begin
      valid <= 1'b1;
      i_out <= i_new;
      q_out <= q_new;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_demod_top.sv
module iq_demod_top
  import iq_demod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         resync,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q
);
  phase_t       phase;
  logic         adv, group_done;
  logic [W-1:0] held [HELD_SAMPLES];
  logic [W-1:0] i_calc, q_calc;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready && !resync;

  iq_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .resync(resync), .adv(adv),
    .phase(phase), .group_done(group_done)
  );

  iq_sample_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase),
    .din(in_data), .held(held)
  );

  iq_half_diff #(.W(W)) u_i (.pos(held[0]), .neg(held[2]), .res(i_calc));
  iq_half_diff #(.W(W)) u_q (.pos(held[1]), .neg(in_data), .res(q_calc));

  iq_out_reg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(group_done),
    .i_new(i_calc), .q_new(q_calc), .take(out_ready),
    .valid(out_valid), .i_out(out_i), .q_out(out_q)
  );
endmodule

// File: rtl/iq_demod_chk.sv
module iq_demod_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         resync,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_i,
  input logic [W-1:0] out_q
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [1:0] seen;
  logic       acc;
  assign acc = in_valid && in_ready && !resync;

  always_ff @(posedge clk) begin
    if (!rst_n || resync) seen <= 2'd0;
    else if (acc)         seen <= seen + 2'd1;
  end

  // R5: fourth accepted sample raises the strobe
  p_group_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seen == 2'd3 |=> out_valid);

  // R5: strobe rises only after an accepted phase-3 sample
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc && seen == 2'd3));

  // R6: resync never completes a group
  p_resync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !$rose(out_valid));

  // R7: stalled pair is held
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  // R3: saturation keeps the most negative code away
  p_no_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != MOST_NEG) && (out_q != MOST_NEG));

  // R9: taken pair clears when no group completes
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(acc && seen == 2'd3) |=> !out_valid);
endmodule

bind iq_demod_top iq_demod_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .resync(resync), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_iq_demod_top.sv
module sim_iq_demod_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resync = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_i, out_q;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  iq_demod_top u0 (
    .clk(clk), .rst_n(rst_n), .resync(resync), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  // s0, s1, s2, s3, expected I, expected Q
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV][6] = '{
    '{16'h0064, 16'h0032, 16'hFF9C, 16'hFFCE, 16'h0064, 16'h0032},
    '{16'h0003, 16'h0000, 16'h0000, 16'h0000, 16'h0002, 16'h0000},
    '{16'h0000, 16'h0000, 16'h0003, 16'h0000, 16'hFFFF, 16'h0000},
    '{16'h05DC, 16'h01F4, 16'hFE0C, 16'h01F4, 16'h03E8, 16'h0000},
    '{16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h8001},
    '{16'h0000, 16'h0007, 16'h0000, 16'h0002, 16'h0000, 16'h0003},
    '{16'hFFFB, 16'h0000, 16'hFFFB, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0002, 16'hFFFF, 16'h0001, 16'h0000, 16'h0001, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic put(input logic [15:0] s);
    in_valid = 1'b1;
    in_data  = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic group(input int v, input bit gaps);
    for (int k = 0; k < 4; k++) begin
      put(VEC[v][k]);
      if (gaps && k < 3) idle(2);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", {15'd0, out_valid}, 16'd0);
    chk("R1 in_ready", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      group(v, 1'b0);
      chk($sformatf("R5 valid v%0d", v), {15'd0, out_valid}, 16'd1);
      chk($sformatf("R2 R3 R4 I v%0d", v), out_i, VEC[v][4]);
      chk($sformatf("R2 R3 R4 Q v%0d", v), out_q, VEC[v][5]);
      @(negedge clk);
      chk($sformatf("R9 cleared v%0d", v), {15'd0, out_valid}, 16'd0);
    end

    // R8: gaps between samples
    group(5, 1'b1);
    chk("R8 I gaps", out_i, VEC[5][4]);
    chk("R8 Q gaps", out_q, VEC[5][5]);
    idle(1);

    // R6: partial group discarded
    put(16'h1234);
    put(16'h4321);
    in_valid = 1'b0;
    resync = 1'b1;
    @(negedge clk);
    resync = 1'b0;
    chk("R6 no output", {15'd0, out_valid}, 16'd0);
    group(0, 1'b0);
    chk("R6 I realign", out_i, VEC[0][4]);
    chk("R6 Q realign", out_q, VEC[0][5]);
    idle(1);

    // R6: sample offered during resync is dropped
    put(16'h0700);
    resync = 1'b1;
    put(16'h0555);
    resync = 1'b0;
    group(7, 1'b0);
    chk("R6 drop I", out_i, VEC[7][4]);
    chk("R6 drop Q", out_q, VEC[7][5]);
    idle(1);

    // R7: back-pressure
    out_ready = 1'b0;
    group(1, 1'b0);
    chk("R7 valid", {15'd0, out_valid}, 16'd1);
    in_valid = 1'b1;
    in_data  = VEC[2][0];
    repeat (3) @(negedge clk);
    chk("R7 ready low", {15'd0, in_ready}, 16'd0);
    chk("R7 held valid", {15'd0, out_valid}, 16'd1);
    chk("R7 held I", out_i, VEC[1][4]);
    chk("R7 held Q", out_q, VEC[1][5]);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 taken", {15'd0, out_valid}, 16'd0);
    put(VEC[2][1]);
    put(VEC[2][2]);
    put(VEC[2][3]);
    in_valid = 1'b0;
    chk("R7 resume I", out_i, VEC[2][4]);
    chk("R7 resume Q", out_q, VEC[2][5]);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule